// File: doc/BRIEF.md
# Windowed Watchdog With Violation Counter

This block supervises a host processor with a windowed watchdog. After the watchdog is enabled it opens a startup window. From then on it runs a closed window followed by an open window, over and over. The host must send its service strobe (a "kick") while the open window is running. A kick that arrives too early, during the closed window, counts as a timing violation. So does an open window that runs out with no kick. Each violation restarts the cycle at the closed window.

A saturating counter keeps track of violations. A valid kick clears it. Once the count goes past a programmable tolerance, the block raises a sticky watchdog fault. Two mapping bits pass that fault on as a reset request and as an interrupt request. An active-low watchdog output reflects the fault, and a force bit can pull that output low at any time.

All window timing is counted in ticks of an external 1 ms strobe. Each window length comes from an 8-bit field by a linear rule, so the block needs no lookup table.

Top module: `wdog_window_supervisor`

## Requirements
- R1: After reset, `wd_fault` is 0, `wdo_n` is 1, and both `rst_req` and `irq_req` are 0, whatever the mapping bits are.
- R2: The closed window lasts `close_time*3+1` ticks and the open window lasts `open_time*3+1` ticks. Each window counts ticks from its own start.
- R3: The watchdog runs only while `en_pin` and `en_ctl` are both 1. While either one is 0, kicks and ticks have no effect and the fault is cleared on the next cycle.
- R4: The first window after enabling is a startup window of `(open_time*3+1)*(startup_mult+1)` ticks. It has no closed part, so a kick anywhere in it is valid. If it runs out with no kick, that is a violation. The startup window begins on the cycle after the enable condition becomes true.
- R5: A kick during the closed window is a violation and restarts the closed window.
- R6: An open window that runs out with no kick is a violation and starts a new closed window.
- R7: A kick during the open window, or during the startup window, clears the violation count and starts a closed window.
- R8: `wd_fault` rises on the clock edge of the violation that brings the count above `max_viol`, where `max_viol` is a plain binary value from 0 to 7. With `max_viol`=0 the first violation faults, and with `max_viol`=7 the eighth violation faults.
- R9: `wd_fault` stays at 1 through later kicks and violations until the watchdog is disabled or the block is reset.
- R10: `rst_req` equals `wd_fault` AND `map_rst`, and `irq_req` equals `wd_fault` AND `map_irq`.
- R11: `wdo_n` is 0 whenever `force_low` is 1. Otherwise `wdo_n` is the inverse of `wd_fault`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_ms | input | 1 | One-cycle strobe every millisecond |
| kick | input | 1 | One-cycle service strobe from the host |
| en_pin | input | 1 | Hardware enable |
| en_ctl | input | 1 | Register enable bit |
| close_time | input | 8 | Closed window length code |
| open_time | input | 8 | Open window length code |
| startup_mult | input | 3 | Startup window multiplier, 0 to 7 |
| max_viol | input | 3 | Violations tolerated before fault, 0 to 7 |
| map_rst | input | 1 | Route fault to reset request |
| map_irq | input | 1 | Route fault to interrupt request |
| force_low | input | 1 | Force watchdog output low |
| wd_fault | output | 1 | Sticky watchdog fault |
| rst_req | output | 1 | Fault mapped to reset |
| irq_req | output | 1 | Fault mapped to interrupt |
| wdo_n | output | 1 | Active-low watchdog output |

## Verification
The bench builds the block with its default parameters: 8-bit window codes, a 3-bit multiplier, a 3-bit tolerance and the ×3+1 length rule. The bench generates the millisecond tick itself, so window codes of 0 to 2 give windows of 1 to 14 ticks. Those short windows let every window boundary, the full multiplied startup window, and the highest tolerance of seven violations be reached one tick at a time.

// File: rtl/wdw_pkg.sv
package wdw_pkg;
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_START = 2'd1,
        S_CLOSE = 2'd2,
        S_OPEN  = 2'd3
    } wd_state_e;
endpackage

// File: rtl/wdw_winlen.sv
module wdw_winlen #(
    parameter int FIELD_W = 8,
    parameter int SCALE   = 3,
    parameter int OFFSET  = 1,
    parameter int LEN_W   = 10
) (
    input  logic [FIELD_W-1:0] code,
    output logic [LEN_W-1:0]   len
);
    // ticks = code * SCALE + OFFSET
    assign len = LEN_W'(code) * LEN_W'(SCALE) + LEN_W'(OFFSET);
endmodule

// File: rtl/wdw_viol_ctr.sv
module wdw_viol_ctr #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             viol,
    input  logic             good,
    input  logic [CNT_W-1:0] max_viol,
    output logic             fault
);
    typedef struct packed {
        logic [CNT_W:0] cnt;
        logic           fault;
    } ctr_t;

    ctr_t ctr_d, ctr_q;
    logic [CNT_W:0] cnt_inc;

    always_comb begin
        ctr_d   = ctr_q;
        cnt_inc = (ctr_q.cnt == '1) ? ctr_q.cnt : ctr_q.cnt + 1'b1;
        if (!run) begin
            ctr_d = '0;
        end else if (good) begin
            ctr_d.cnt = '0;
        end else if (viol) begin
            ctr_d.cnt = cnt_inc;
            if (cnt_inc > {1'b0, max_viol}) begin
                ctr_d.fault = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctr_q <= '0;
        else        ctr_q <= ctr_d;
    end

    assign fault = ctr_q.fault;

    // R7: a valid kick empties the violation count
    a_r7_good_clears: assert property (@(posedge clk) disable iff (!rst_n)
        good |=> (ctr_q.cnt == '0));

    // R9: fault holds while the watchdog keeps running
    a_r9_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (run && ctr_q.fault) |=> ctr_q.fault);

    // R8: fault only rises on a violation
    a_r8_rise_on_viol: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctr_q.fault) |-> $past(viol));
endmodule

// File: rtl/wdog_window_supervisor.sv
module wdog_window_supervisor #(
    parameter int FIELD_W = 8,
    parameter int MULT_W  = 3,
    parameter int CNT_W   = 3,
    parameter int SCALE   = 3,
    parameter int OFFSET  = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_ms,
    input  logic               kick,
    input  logic               en_pin,
    input  logic               en_ctl,
    input  logic [FIELD_W-1:0] close_time,
    input  logic [FIELD_W-1:0] open_time,
    input  logic [MULT_W-1:0]  startup_mult,
    input  logic [CNT_W-1:0]   max_viol,
    input  logic               map_rst,
    input  logic               map_irq,
    input  logic               force_low,
    output logic               wd_fault,
    output logic               rst_req,
    output logic               irq_req,
    output logic               wdo_n
);
    import wdw_pkg::*;

    localparam int WIN_MAX = (2**FIELD_W - 1) * SCALE + OFFSET;
    localparam int WIN_W   = $clog2(WIN_MAX + 1);
    localparam int TMR_W   = $clog2(WIN_MAX * (2**MULT_W) + 1);
    localparam int N_WIN   = 2;

    typedef struct packed {
        wd_state_e        state;
        logic [TMR_W-1:0] tmr;
    } wd_reg_t;

    wd_reg_t wd_d, wd_q;

    logic [N_WIN-1:0][FIELD_W-1:0] win_code;
    logic [WIN_W-1:0]              win_len [N_WIN];
    logic [TMR_W-1:0]              start_len;
    logic [TMR_W-1:0]              cur_len;
    logic                          run, expire, viol, good;

    assign win_code[0] = close_time;
    assign win_code[1] = open_time;

    for (genvar g = 0; g < N_WIN; g++) begin : g_win
        wdw_winlen #(
            .FIELD_W (FIELD_W),
            .SCALE   (SCALE),
            .OFFSET  (OFFSET),
            .LEN_W   (WIN_W)
        ) u_len (
            .code (win_code[g]),
            .len  (win_len[g])
        );
    end

    assign run       = en_pin & en_ctl;
    assign start_len = TMR_W'(win_len[1]) * (TMR_W'(startup_mult) + TMR_W'(1));

    always_comb begin
        wd_d = wd_q;
        viol = 1'b0;
        good = 1'b0;
        case (wd_q.state)
            S_START: cur_len = start_len;
            S_CLOSE: cur_len = TMR_W'(win_len[0]);
            default: cur_len = TMR_W'(win_len[1]);
        endcase
        expire = tick_ms && (wd_q.tmr == cur_len - 1'b1);

        if (!run) begin
            wd_d.state = S_IDLE;
            wd_d.tmr   = '0;
        end else begin
            case (wd_q.state)
                S_IDLE: begin
                    wd_d.state = S_START;
                    wd_d.tmr   = '0;
                end
                S_START, S_OPEN: begin
                    if (kick) begin
                        good       = 1'b1;
                        wd_d.state = S_CLOSE;
                        wd_d.tmr   = '0;
                    end else if (expire) begin
                        viol       = 1'b1;
                        wd_d.state = S_CLOSE;
                        wd_d.tmr   = '0;
                    end else if (tick_ms) begin
                        wd_d.tmr = wd_q.tmr + 1'b1;
                    end
                end
                default: begin // S_CLOSE
                    if (kick) begin
                        viol     = 1'b1;
                        wd_d.tmr = '0;
                    end else if (expire) begin
                        wd_d.state = S_OPEN;
                        wd_d.tmr   = '0;
                    end else if (tick_ms) begin
                        wd_d.tmr = wd_q.tmr + 1'b1;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wd_q <= '{state: S_IDLE, tmr: '0};
        else        wd_q <= wd_d;
    end

    wdw_viol_ctr #(
        .CNT_W (CNT_W)
    ) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .viol     (viol),
        .good     (good),
        .max_viol (max_viol),
        .fault    (wd_fault)
    );

    assign rst_req = wd_fault & map_rst;
    assign irq_req = wd_fault & map_irq;
    assign wdo_n   = ~(wd_fault | force_low);

    // R3: disabled watchdog parks in idle
    a_r3_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (wd_q.state == S_IDLE && wd_q.tmr == '0));

    // R5: early kick restarts the closed window
    a_r5_early_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (run && wd_q.state == S_CLOSE && kick) |=> (wd_q.state == S_CLOSE && wd_q.tmr == '0));

    // R4: enabling always passes through the startup window
    a_r4_start_first: assert property (@(posedge clk) disable iff (!rst_n)
        (run && wd_q.state == S_IDLE) |=> (wd_q.state == S_START));
endmodule

// File: tb/sim_wdog_window_supervisor.sv
module sim_wdog_window_supervisor;
    logic       clk = 1'b0;
    logic       rst_n, tick_ms, kick, en_pin, en_ctl;
    logic [7:0] close_time, open_time;
    logic [2:0] startup_mult, max_viol;
    logic       map_rst, map_irq, force_low;
    logic       wd_fault, rst_req, irq_req, wdo_n;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    wdog_window_supervisor u0 (
        .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .kick(kick),
        .en_pin(en_pin), .en_ctl(en_ctl), .close_time(close_time),
        .open_time(open_time), .startup_mult(startup_mult), .max_viol(max_viol),
        .map_rst(map_rst), .map_irq(map_irq), .force_low(force_low),
        .wd_fault(wd_fault), .rst_req(rst_req), .irq_req(irq_req), .wdo_n(wdo_n)
    );

    // {tick, kick, expected fault}; close=1 tick, open=4 ticks, startup=4, max_viol=1
    localparam logic [2:0] VEC [13] = '{
        3'b010, 3'b010, 3'b100, 3'b010, 3'b010, 3'b100, 3'b100,
        3'b100, 3'b100, 3'b101, 3'b011, 3'b101, 3'b011
    };

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic step(input logic t, input logic k);
        tick_ms = t;
        kick    = k;
        @(negedge clk);
        tick_ms = 1'b0;
        kick    = 1'b0;
    endtask

    task automatic set_en(input logic p, input logic c);
        en_pin = p;
        en_ctl = c;
        step(1'b0, 1'b0);
    endtask

    initial begin
        rst_n = 1'b0; tick_ms = 1'b0; kick = 1'b0; en_pin = 1'b0; en_ctl = 1'b0;
        close_time = '0; open_time = '0; startup_mult = '0; max_viol = '0;
        map_rst = 1'b1; map_irq = 1'b1; force_low = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 fault", wd_fault, 0);
        chk("R1 wdo_n", wdo_n, 1);
        chk("R1 rst_req", rst_req, 0);
        chk("R1 irq_req", irq_req, 0);

        // table: R5 R6 R7 R8 R9
        close_time = 8'd0; open_time = 8'd1; startup_mult = 3'd0; max_viol = 3'd1;
        set_en(1'b1, 1'b1);
        for (int i = 0; i < 13; i++) begin
            step(VEC[i][2], VEC[i][1]);
            chk($sformatf("R5_R6_R7_R8_R9 vec%0d", i), wd_fault, VEC[i][0]);
        end

        // R10 mapping
        map_rst = 1'b1; map_irq = 1'b0; #1;
        chk("R10 rst_req", rst_req, 1);
        chk("R10 irq_req", irq_req, 0);
        map_rst = 1'b0; map_irq = 1'b1; #1;
        chk("R10 rst_req", rst_req, 0);
        chk("R10 irq_req", irq_req, 1);
        chk("R11 wdo_n on fault", wdo_n, 0);

        // R3 disable clears fault
        set_en(1'b1, 1'b0);
        chk("R3 cleared", wd_fault, 0);
        force_low = 1'b1; #1;
        chk("R11 forced", wdo_n, 0);
        force_low = 1'b0; #1;
        chk("R11 released", wdo_n, 1);

        // R3 ignored while one enable is low
        max_viol = 3'd0;
        for (int i = 0; i < 3; i++) step(1'b0, 1'b1);
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0);
        chk("R3 reg off", wd_fault, 0);
        set_en(1'b0, 1'b1);
        for (int i = 0; i < 3; i++) step(1'b0, 1'b1);
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0);
        chk("R3 pin off", wd_fault, 0);
        set_en(1'b0, 1'b0);

        // R4 startup = 7*2 = 14 ticks
        close_time = 8'd0; open_time = 8'd2; startup_mult = 3'd1; max_viol = 3'd0;
        set_en(1'b1, 1'b1);
        for (int i = 0; i < 13; i++) step(1'b1, 1'b0);
        chk("R4 before end", wd_fault, 0);
        step(1'b1, 1'b0);
        chk("R4 at end", wd_fault, 1);
        set_en(1'b0, 1'b0);

        // R2 closed window of 4 ticks
        close_time = 8'd1; open_time = 8'd0; startup_mult = 3'd0;
        set_en(1'b1, 1'b1);
        step(1'b0, 1'b1);
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0);
        step(1'b0, 1'b1);
        chk("R2 still closed", wd_fault, 1);
        set_en(1'b0, 1'b0);
        set_en(1'b1, 1'b1);
        step(1'b0, 1'b1);
        for (int i = 0; i < 4; i++) step(1'b1, 1'b0);
        step(1'b0, 1'b1);
        chk("R2 now open", wd_fault, 0);
        set_en(1'b0, 1'b0);

        // R8 tolerance 7
        close_time = 8'd0; open_time = 8'd0; max_viol = 3'd7;
        set_en(1'b1, 1'b1);
        step(1'b0, 1'b1);
        for (int i = 0; i < 7; i++) step(1'b0, 1'b1);
        chk("R8 seven", wd_fault, 0);
        step(1'b0, 1'b1);
        chk("R8 eighth", wd_fault, 1);

        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule